// File: doc/BRIEF.md
# DRAM Power-Down State Controller

This block follows the power state of a low-power DRAM device. It watches the clock enable input and the command presented with it. On the first cycle in which clock enable is sampled low, the current command and a bank-open indication choose which low-power state the device enters. A bank that is still open forces active power-down, in which state is frozen. A no-operation command selects idle power-down. A refresh encoding selects self-refresh. A burst-terminate encoding selects deep power-down, in which all stored contents are lost.

When clock enable rises again, the device returns from active power-down, idle power-down or self-refresh to normal operation. Leaving deep power-down is different: the device goes to an uninitialised state and waits for an external signal that reports a completed initialisation sequence. The controller drives a clock-enable gate for the array, a self-refresh flag for an internal refresh timer, and a contents-lost flag. It forwards commands only while the device is running. Commands that arrive in any other state are flagged as illegal.

Top module: `dram_pwr_ctrl`

## Requirements
- R1: After reset the state output is 5 (uninitialised), array_en_o is 0 and contents_lost_o is 1.
- R2: In state 5 the controller stays put until init_done_i and cke_i are both high in the same cycle, then enters state 0 (running) on the next cycle.
- R3: In state 0 with cke_i high, a non-NOP command raises cmd_fwd_o in that cycle and does not raise cmd_illegal_o. A NOP raises neither output. array_en_o is 1 in state 0 only.
- R4: In state 0, if cke_i is low and bank_open_i is high, the next state is 1 (active power-down), whatever the command.
- R5: A NOP in the cycle where cke_i is low in state 0, with no bank open, gives next state 2 (idle power-down). A NOP is either cs_ni = 1, or ca_i = 3'b111, where ca_i[0] is CA0, ca_i[1] is CA1 and ca_i[2] is CA2.
- R6: A refresh encoding (cs_ni = 0, CA0 = 0, CA1 = 0, CA2 = 1, so ca_i = 3'b100) in that cycle gives state 3 (self-refresh). self_ref_o stays 1 for every cycle spent in state 3.
- R7: A burst-terminate encoding (cs_ni = 0, CA0 = 1, CA1 = 1, CA2 = 0, so ca_i = 3'b011) in that cycle gives state 4 (deep power-down), and contents_lost_o is 1 there.
- R8: Any other command in that cycle, with no bank open, gives state 2 and raises cmd_illegal_o in that cycle.
- R9: The command in the cycle where clock enable falls is never forwarded.
- R10: In states 1, 2 and 3 the state holds while cke_i is low. It returns to 0 on the cycle after cke_i is sampled high.
- R11: In state 4, cke_i high gives state 5 on the next cycle, and R2 then applies.
- R12: In every state other than 0, cmd_fwd_o stays 0 and any non-NOP command raises cmd_illegal_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Device clock enable |
| cs_ni | input | 1 | Chip select, active low; high means NOP |
| ca_i | input | 3 | Command bits CA0..CA2 (bit 0 = CA0) |
| bank_open_i | input | 1 | At least one bank is open |
| init_done_i | input | 1 | Initialisation sequence complete |
| pwr_state_o | output | 3 | Power state: 0 run, 1 active PD, 2 idle PD, 3 self-refresh, 4 deep PD, 5 uninit |
| array_en_o | output | 1 | Array clock gate enable |
| self_ref_o | output | 1 | Self-refresh timer enable |
| contents_lost_o | output | 1 | Stored data is invalid |
| cmd_fwd_o | output | 1 | Current command is passed on to the array |
| cmd_illegal_o | output | 1 | Current command arrived in a state that cannot accept it |

## Verification
The in-RTL assertions check on every cycle the rules between adjacent steps. Deep power-down exits only to the uninitialised state. Power-down states hold while clock enable is low. The self-refresh flag stays asserted. A forwarded command is never also flagged illegal, and it is always followed by a cycle in the running state. Only the bench scenarios can show the choice of entry state for each command and bank-open combination, the full round trip from deep power-down through reinitialisation, and the NOP decoding through chip select versus the CA bits.

// File: rtl/dram_pwr_pkg.sv
package dram_pwr_pkg;
  localparam int CA_W    = 3;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    PS_RUN      = 3'd0,
    PS_ACT_PD   = 3'd1,
    PS_IDLE_PD  = 3'd2,
    PS_SELF_REF = 3'd3,
    PS_DEEP_PD  = 3'd4,
    PS_UNINIT   = 3'd5
  } pwr_state_e;

  typedef enum logic [1:0] {
    CK_NOP,
    CK_REF,
    CK_BST,
    CK_OTHER
  } cmd_kind_e;

  // CA bits as {CA2, CA1, CA0}
  localparam logic [CA_W-1:0] CA_NOP = 3'b111;
  localparam logic [CA_W-1:0] CA_REF = 3'b100;
  localparam logic [CA_W-1:0] CA_BST = 3'b011;
endpackage

// File: rtl/dram_pwr_cmd_dec.sv
module dram_pwr_cmd_dec
  import dram_pwr_pkg::*;
(
  input  logic            cs_ni,
  input  logic [CA_W-1:0] ca_i,
  output cmd_kind_e       kind_o
);
  always_comb begin
    if (cs_ni)                kind_o = CK_NOP;
    else if (ca_i == CA_NOP)  kind_o = CK_NOP;
    else if (ca_i == CA_REF)  kind_o = CK_REF;
    else if (ca_i == CA_BST)  kind_o = CK_BST;
    else                      kind_o = CK_OTHER;
  end
endmodule

// File: rtl/dram_pwr_fsm.sv
module dram_pwr_fsm
  import dram_pwr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cke_i,
  input  cmd_kind_e  kind_i,
  input  logic       bank_open_i,
  input  logic       init_done_i,
  output pwr_state_e state_o
);
  pwr_state_e state_q, state_d;

  // Entry state picked by the command on the first low CKE sample
  function automatic pwr_state_e pd_entry(input logic bank, input cmd_kind_e k);
    if (bank) return PS_ACT_PD;
    unique case (k)
      CK_REF:  return PS_SELF_REF;
      CK_BST:  return PS_DEEP_PD;
      default: return PS_IDLE_PD;
    endcase
  endfunction

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_RUN:                              if (!cke_i) state_d = pd_entry(bank_open_i, kind_i);
      PS_ACT_PD, PS_IDLE_PD, PS_SELF_REF:  if (cke_i) state_d = PS_RUN;
      PS_DEEP_PD:                          if (cke_i) state_d = PS_UNINIT;
      PS_UNINIT:                           if (cke_i && init_done_i) state_d = PS_RUN;
      default:                             state_d = PS_UNINIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PS_UNINIT;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  assert_deep_exit_uninit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_DEEP_PD && cke_i) |=> state_q == PS_UNINIT);

  assert_pd_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {PS_ACT_PD, PS_IDLE_PD, PS_SELF_REF, PS_DEEP_PD} && !cke_i) |=> $stable(state_q));

  assert_uninit_wait_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_UNINIT && !init_done_i) |=> state_q == PS_UNINIT);

  assert_active_pd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_RUN && !cke_i && bank_open_i) |=> state_q == PS_ACT_PD);
endmodule

// File: rtl/dram_pwr_gate.sv
module dram_pwr_gate
  import dram_pwr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  pwr_state_e state_i,
  input  logic       cke_i,
  input  logic       bank_open_i,
  input  cmd_kind_e  kind_i,
  output logic       array_en_o,
  output logic       self_ref_o,
  output logic       lost_o,
  output logic       fwd_o,
  output logic       illegal_o
);
  logic running, cmd_live, fall_bad;

  assign running    = (state_i == PS_RUN);
  assign cmd_live   = (kind_i != CK_NOP);
  // Unrecognised selector on the falling cycle with no bank open
  assign fall_bad   = running && !cke_i && !bank_open_i && (kind_i == CK_OTHER);

  assign array_en_o = running;
  assign self_ref_o = (state_i == PS_SELF_REF);
  assign lost_o     = (state_i == PS_DEEP_PD) || (state_i == PS_UNINIT);
  assign fwd_o      = running && cke_i && cmd_live;
  assign illegal_o  = cmd_live && (!running || fall_bad);

  assert_fwd_xor_illegal_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fwd_o && illegal_o));

  assert_fwd_stays_run_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_o |=> state_i == PS_RUN);

  assert_sref_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (self_ref_o && !cke_i) |=> self_ref_o);

  assert_no_fwd_on_fall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && !cke_i) |-> !fwd_o);
endmodule

// File: rtl/dram_pwr_ctrl.sv
module dram_pwr_ctrl
  import dram_pwr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cke_i,
  input  logic               cs_ni,
  input  logic [CA_W-1:0]    ca_i,
  input  logic               bank_open_i,
  input  logic               init_done_i,
  output logic [STATE_W-1:0] pwr_state_o,
  output logic               array_en_o,
  output logic               self_ref_o,
  output logic               contents_lost_o,
  output logic               cmd_fwd_o,
  output logic               cmd_illegal_o
);
  cmd_kind_e  kind;
  pwr_state_e state;

  dram_pwr_cmd_dec u_dec (
    .cs_ni  (cs_ni),
    .ca_i   (ca_i),
    .kind_o (kind)
  );

  dram_pwr_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cke_i       (cke_i),
    .kind_i      (kind),
    .bank_open_i (bank_open_i),
    .init_done_i (init_done_i),
    .state_o     (state)
  );

  dram_pwr_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .cke_i       (cke_i),
    .bank_open_i (bank_open_i),
    .kind_i      (kind),
    .array_en_o  (array_en_o),
    .self_ref_o  (self_ref_o),
    .lost_o      (contents_lost_o),
    .fwd_o       (cmd_fwd_o),
    .illegal_o   (cmd_illegal_o)
  );

  assign pwr_state_o = state;
endmodule

// File: tb/sim_dram_pwr_ctrl.sv
module sim_dram_pwr_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cke = 1'b0, cs_n = 1'b1, bank = 1'b0, init = 1'b0;
  logic [2:0] ca = 3'b111;
  logic [2:0] st;
  logic       arr, sref, lost, fwd, ill;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  dram_pwr_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cke_i(cke), .cs_ni(cs_n), .ca_i(ca),
    .bank_open_i(bank), .init_done_i(init), .pwr_state_o(st),
    .array_en_o(arr), .self_ref_o(sref), .contents_lost_o(lost),
    .cmd_fwd_o(fwd), .cmd_illegal_o(ill)
  );

  typedef struct {
    logic [2:0] st;
    logic arr, sref, lost, fwd, ill;
    string tag;
  } exp_t;

  exp_t q[$];
  logic [2:0] m = 3'd5;  // model state

  // 0 nop, 1 refresh, 2 burst terminate, 3 other
  function automatic int kind_of(input logic c, input logic [2:0] a);
    if (c || a == 3'b111) return 0;
    if (a == 3'b100) return 1;
    if (a == 3'b011) return 2;
    return 3;
  endfunction

  task automatic step(input logic k, input logic c, input logic [2:0] a,
                      input logic b, input logic i, input string tag);
    exp_t e;
    int kd;
    @(posedge clk); #1;
    cke = k; cs_n = c; ca = a; bank = b; init = i;
    kd = kind_of(c, a);
    e.st   = m;
    e.arr  = (m == 3'd0);
    e.sref = (m == 3'd3);
    e.lost = (m == 3'd4) || (m == 3'd5);
    e.fwd  = (m == 3'd0) && k && kd != 0;
    e.ill  = (kd != 0) && ((m != 3'd0) || (!k && !b && kd == 3));
    e.tag  = tag;
    q.push_back(e);
    case (m)
      3'd0: if (!k) m = b ? 3'd1 : (kd == 1) ? 3'd3 : (kd == 2) ? 3'd4 : 3'd2;
      3'd1, 3'd2, 3'd3: if (k) m = 3'd0;
      3'd4: if (k) m = 3'd5;
      default: if (k && i) m = 3'd0;
    endcase
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (st !== e.st || arr !== e.arr || sref !== e.sref || lost !== e.lost ||
          fwd !== e.fwd || ill !== e.ill) begin
        fails++;
        $display("FAIL %s: st/arr/sref/lost/fwd/ill actual %0d/%b/%b/%b/%b/%b expected %0d/%b/%b/%b/%b/%b",
                 e.tag, st, arr, sref, lost, fwd, ill,
                 e.st, e.arr, e.sref, e.lost, e.fwd, e.ill);
      end
    end
  end

  initial begin
    #4000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #9 rst_ni = 1'b1;
    // R1 reset state, R2 stays uninit and rejects commands
    step(0, 1, 3'b111, 0, 0, "R1");
    step(1, 0, 3'b010, 0, 0, "R2");
    step(0, 1, 3'b111, 0, 1, "R2");
    step(1, 1, 3'b111, 0, 1, "R2");
    // R3 running: forward, NOP and cs high
    step(1, 0, 3'b010, 0, 0, "R3");
    step(1, 0, 3'b111, 0, 0, "R3");
    step(1, 1, 3'b000, 0, 0, "R3");
    // R4 bank open wins over refresh; R9 not forwarded
    step(0, 0, 3'b100, 1, 0, "R4");
    step(0, 0, 3'b010, 1, 0, "R12");
    step(0, 1, 3'b111, 0, 0, "R10");
    step(1, 1, 3'b111, 0, 0, "R10");
    // R5 idle via cs high, then via CA=111
    step(0, 1, 3'b000, 0, 0, "R5");
    step(1, 1, 3'b111, 0, 0, "R5");
    step(0, 0, 3'b111, 0, 0, "R5");
    step(1, 0, 3'b001, 0, 0, "R12");
    // R6 self-refresh, held three cycles
    step(0, 0, 3'b100, 0, 0, "R6");
    step(0, 1, 3'b111, 0, 0, "R6");
    step(0, 0, 3'b100, 0, 0, "R6");
    step(0, 1, 3'b111, 0, 0, "R6");
    step(1, 1, 3'b111, 0, 0, "R10");
    // R8 unknown selector on fall
    step(0, 0, 3'b101, 0, 0, "R8");
    step(1, 1, 3'b111, 0, 0, "R8");
    // R7 deep power-down, R11 exit to uninit, R2 reinit
    step(0, 0, 3'b011, 0, 0, "R7");
    step(0, 0, 3'b010, 0, 1, "R7");
    step(1, 1, 3'b111, 0, 1, "R11");
    step(1, 0, 3'b010, 0, 0, "R11");
    step(1, 1, 3'b111, 0, 1, "R2");
    step(1, 0, 3'b110, 0, 0, "R3");
    step(1, 1, 3'b111, 0, 0, "R3");
    @(posedge clk); @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule